// File: doc/BRIEF.md
# NAND Flash Device Command Front End

This block is the device side of a NAND flash interface whose I/O bus is either 8 or 16 bits wide. It watches the chip-enable, command-latch and address-latch lines together with the write and read strobes. It decodes command and address cycles and starts one of four operations once enough address bytes have arrived: identification readout, status readout, page read or page program. A single page-plus-spare byte buffer acts as the storage. Program data lands in this buffer and page reads return it. Ready/busy always reads as ready.

Inside the block, every buffer location and pointer counts bytes. Each bus transfer moves bus-width/8 bytes. On a 16-bit bus the column address supplied by the host counts words, so the block turns it into a byte address once the second address byte has been taken. Identification and status bytes sit in the low lane of the 16-bit bus, and the upper lane reads as zero.

Top module: `nandfe_top`

## Requirements
- R1: After `rstN` is released, no response is pending: `dOut` reads 0 even with `ceN` low, and `rdyBusy` is 1.
- R2: A rising edge of `weN` with `ceN` low captures a command byte (`dIn[7:0]`) when `cle`=1, `ale`=0, an address byte when `ale`=1, `cle`=0, and a data word when both are 0. A write strobe with `ceN` high has no effect.
- R3: Command 0x90 followed by one address byte starts the identification response, four transfers in this order: manufacturer code, device code, 0x51, then a fourth byte. The fourth byte is 0xC0 on small-page parts. On large-page parts it is 0x15 for an 8-bit bus and 0x55 for a 16-bit bus (bit 6 marks the wide bus).
- R4: On a 16-bit bus every identification and status transfer carries its byte in `dOut[7:0]` with `dOut[15:8]` = 0.
- R5: Command 0x70 makes the status byte (default 0xC0) available as exactly one transfer. A later read returns 0.
- R6: Page read (command 0x00) and page program (command 0x80) begin only when the address byte count reaches 3 (small page), 4 (large page, 1 Gbit or less) or 5 (large page, 2 Gbit or more). Before that count, reads return 0.
- R7: Address bytes fill the address register low byte first. When the second address byte arrives, the register is shifted left by (bus bytes − 1), so on a 16-bit bus column word N becomes byte address 2N.
- R8: During page program each data word is split into bytes, least significant byte to the lowest buffer address, starting at the column. A word is taken only while the write pointer is below page size plus spare size (2048+64 on large-page parts, 512+16 on small-page parts). Later words are ignored.
- R9: A read with data pending returns bus-width bytes with the lowest address in `dOut[7:0]`. On the rising edge of `reN` the pointer advances by the bus width in bytes and the pending count drops by the same amount. With nothing pending, `dOut` is 0.
- R10: With `ceN` high, `dOut` is 0 and a read strobe consumes nothing.
- R11: Command 0xFF discards any pending response and any operation in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all strobes are sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| weN | input | 1 | Write strobe, action on its rising edge |
| reN | input | 1 | Read strobe, transfer consumed on its rising edge |
| dIn | input | BUS_W | Command, address and write data bus |
| dOut | output | BUS_W | Read data bus |
| rdyBusy | output | 1 | Ready/busy, held at ready (1) |

## Verification
The assertions assume the strobes are slow relative to `clk`. Each low or high phase of `weN` and `reN` lasts at least one clock, and `cle`, `ale`, `ceN` and `dIn` stay stable around the rising edge of a strobe. The bench meets these assumptions by changing every input on the falling clock edge and by holding each strobe phase for a full cycle. The bench also keeps latch and chip-enable values steady until the cycle after the strobe has risen. All column addresses are issued as word addresses below the spare-area end, so pointers stay aligned to the bus width.

// File: rtl/nandfe_pkg.sv
package nandfe_pkg;
  localparam int PTR_BITS = 16;

  localparam logic [7:0] CMD_READ    = 8'h00;
  localparam logic [7:0] CMD_PROGRAM = 8'h80;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_RESET   = 8'hFF;

  typedef enum logic [2:0] {
    M_IDLE,
    M_IDENT,
    M_STATUS,
    M_PAGE,
    M_PROG
  } respMode_e;

  // strobes and state handed from control to datapath
  typedef struct packed {
    logic                wrWord;
    respMode_e           mode;
    logic [PTR_BITS-1:0] ptr;
    logic [PTR_BITS-1:0] remaining;
  } ctrlStrobe_t;
endpackage

// File: rtl/nandfe_ctrl.sv
module nandfe_ctrl
  import nandfe_pkg::*;
#(
  parameter int BUS_W       = 16,
  parameter bit LARGE_PAGE  = 1'b1,
  parameter bit BIG_DEVICE  = 1'b1,
  parameter int TOTAL_BYTES = 2112
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ceN,
  input  logic        cle,
  input  logic        ale,
  input  logic        weN,
  input  logic        reN,
  input  logic [7:0]  cmdByte,
  output ctrlStrobe_t strobe
);
  localparam int BB       = BUS_W / 8;
  localparam int SHIFT    = BB - 1;
  localparam int ADDR_CYC = LARGE_PAGE ? (BIG_DEVICE ? 5 : 4) : 3;
  localparam int COL_BITS = $clog2(TOTAL_BYTES);
  localparam logic [PTR_BITS-1:0] STEP  = PTR_BITS'(BB);
  localparam logic [PTR_BITS-1:0] TOTAL = PTR_BITS'(TOTAL_BYTES);

  logic                weQ, reQ;
  logic [7:0]          cmdReg;
  logic [39:0]         addrReg, addrNext;
  logic [2:0]          addrCnt;
  logic [3:0]          cntNext;
  respMode_e           mode;
  logic [PTR_BITS-1:0] ptr, remaining, colNext;
  logic                weRise, reRise, cmdCyc, adrCyc, datCyc, rdCyc, wrWord;

  assign weRise = weN & ~weQ;
  assign reRise = reN & ~reQ;
  assign cmdCyc = weRise & ~ceN & cle & ~ale;
  assign adrCyc = weRise & ~ceN & ale & ~cle;
  assign datCyc = weRise & ~ceN & ~cle & ~ale;
  assign rdCyc  = reRise & ~ceN & (remaining != '0);
  assign wrWord = datCyc & (mode == M_PROG) & (ptr < TOTAL);
  assign cntNext = {1'b0, addrCnt} + 4'd1;

  // place the incoming address byte, then scale the column after byte two
  always_comb begin
    addrNext = addrReg;
    for (int i = 0; i < 5; i++) begin
      if (addrCnt == 3'(i)) addrNext[i*8 +: 8] = cmdByte;
    end
    if (addrCnt == 3'd1) addrNext = addrNext << SHIFT;
    colNext = PTR_BITS'(addrNext[COL_BITS-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      weQ       <= 1'b1;
      reQ       <= 1'b1;
      cmdReg    <= CMD_RESET;
      addrReg   <= '0;
      addrCnt   <= '0;
      mode      <= M_IDLE;
      ptr       <= '0;
      remaining <= '0;
    end else begin
      weQ <= weN;
      reQ <= reN;
      if (cmdCyc) begin
        cmdReg  <= cmdByte;
        addrReg <= '0;
        addrCnt <= '0;
        ptr     <= '0;
        if (cmdByte == CMD_STATUS) begin
          mode      <= M_STATUS;
          remaining <= STEP;
        end else begin
          mode      <= M_IDLE;
          remaining <= '0;
        end
      end else if (adrCyc) begin
        addrReg <= addrNext;
        addrCnt <= (addrCnt == 3'd7) ? addrCnt : cntNext[2:0];
        if (cmdReg == CMD_IDENT && cntNext == 4'd1) begin
          mode      <= M_IDENT;
          ptr       <= '0;
          remaining <= PTR_BITS'(4 * BB);
        end else if (cntNext == 4'(ADDR_CYC) && cmdReg == CMD_READ) begin
          mode      <= M_PAGE;
          ptr       <= colNext;
          remaining <= (colNext < TOTAL) ? (TOTAL - colNext) : '0;
        end else if (cntNext == 4'(ADDR_CYC) && cmdReg == CMD_PROGRAM) begin
          mode      <= M_PROG;
          ptr       <= colNext;
          remaining <= '0;
        end
      end else if (wrWord) begin
        ptr <= ptr + STEP;
      end else if (rdCyc) begin
        ptr       <= ptr + STEP;
        remaining <= (remaining > STEP) ? (remaining - STEP) : '0;
      end
    end
  end

  assign strobe = '{wrWord: wrWord, mode: mode, ptr: ptr, remaining: remaining};

  a_r6_page_after_count: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mode == M_PAGE) |-> (addrCnt == 3'(ADDR_CYC)));
  a_r3_ident_length: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mode == M_IDENT) |-> (remaining == PTR_BITS'(4 * BB) && ptr == '0));
  a_r5_status_single: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mode == M_STATUS) |-> (remaining == STEP));
  a_r9_read_step: assert property (@(posedge clk) disable iff (!rstN)
    (rdCyc && !weRise) |=> (ptr == $past(ptr) + STEP));
  a_r10_ce_holds: assert property (@(posedge clk) disable iff (!rstN)
    (ceN && !weRise) |=> $stable(remaining));
endmodule

// File: rtl/nandfe_data.sv
module nandfe_data
  import nandfe_pkg::*;
#(
  parameter int         BUS_W       = 16,
  parameter bit         LARGE_PAGE  = 1'b1,
  parameter int         TOTAL_BYTES = 2112,
  parameter logic [7:0] MFR_CODE    = 8'h3A,
  parameter logic [7:0] DEV_CODE    = 8'h5C,
  parameter logic [7:0] STATUS_BYTE = 8'hC0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceN,
  input  logic [BUS_W-1:0] dIn,
  input  ctrlStrobe_t      strobe,
  output logic [BUS_W-1:0] dOut
);
  localparam int BB     = BUS_W / 8;
  localparam int SHIFT  = BB - 1;
  localparam int IDX_W  = $clog2(TOTAL_BYTES);
  localparam logic [7:0] FOURTH = LARGE_PAGE ? ((BB == 2) ? 8'h55 : 8'h15) : 8'hC0;
  localparam logic [PTR_BITS-1:0] TOTAL = PTR_BITS'(TOTAL_BYTES);

  logic [7:0] mem [TOTAL_BYTES];
  logic       active;

  function automatic logic [7:0] identByte(input logic [1:0] slot);
    case (slot)
      2'd0:    return MFR_CODE;
      2'd1:    return DEV_CODE;
      2'd2:    return 8'h51;
      default: return FOURTH;
    endcase
  endfunction

  // program data: low byte of the word to the lowest address
  always_ff @(posedge clk) begin
    if (strobe.wrWord) begin
      for (int l = 0; l < BB; l++) begin
        if (strobe.ptr + PTR_BITS'(l) < TOTAL)
          mem[IDX_W'(strobe.ptr + PTR_BITS'(l))] <= dIn[l*8 +: 8];
      end
    end
  end

  assign active = ~ceN & (strobe.remaining != '0);

  for (genvar l = 0; l < BB; l++) begin : g_lane
    logic [PTR_BITS-1:0] k, slot;
    logic [7:0]          laneByte;
    assign k    = strobe.ptr + PTR_BITS'(l);
    assign slot = k >> SHIFT;
    always_comb begin
      laneByte = 8'h00;
      case (strobe.mode)
        M_IDENT:  if (((k & PTR_BITS'(SHIFT)) == '0) && slot < 16'd4)
                    laneByte = identByte(slot[1:0]);
        M_STATUS: if (k == '0) laneByte = STATUS_BYTE;
        M_PAGE:   if (k < TOTAL) laneByte = mem[IDX_W'(k)];
        default:  laneByte = 8'h00;
      endcase
    end
    assign dOut[l*8 +: 8] = active ? laneByte : 8'h00;
  end

  a_r10_idle_bus: assert property (@(posedge clk) disable iff (!rstN)
    ceN |-> (dOut == '0));
  if (BB == 2) begin : g_wide_chk
    a_r4_upper_lane_zero: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.mode == M_IDENT || strobe.mode == M_STATUS) |-> (dOut[BUS_W-1:8] == 8'h00));
  end
endmodule

// File: rtl/nandfe_top.sv
module nandfe_top
  import nandfe_pkg::*;
#(
  parameter int         BUS_W       = 16,
  parameter bit         LARGE_PAGE  = 1'b1,
  parameter bit         BIG_DEVICE  = 1'b1,
  parameter logic [7:0] MFR_CODE    = 8'h3A,
  parameter logic [7:0] DEV_CODE    = 8'h5C,
  parameter logic [7:0] STATUS_BYTE = 8'hC0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceN,
  input  logic             cle,
  input  logic             ale,
  input  logic             weN,
  input  logic             reN,
  input  logic [BUS_W-1:0] dIn,
  output logic [BUS_W-1:0] dOut,
  output logic             rdyBusy
);
  localparam int PAGE_BYTES  = LARGE_PAGE ? 2048 : 512;
  localparam int TOTAL_BYTES = PAGE_BYTES + PAGE_BYTES / 32;

  ctrlStrobe_t strobe;

  nandfe_ctrl #(
    .BUS_W(BUS_W), .LARGE_PAGE(LARGE_PAGE), .BIG_DEVICE(BIG_DEVICE),
    .TOTAL_BYTES(TOTAL_BYTES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .cle(cle), .ale(ale),
    .weN(weN), .reN(reN), .cmdByte(dIn[7:0]), .strobe(strobe)
  );

  nandfe_data #(
    .BUS_W(BUS_W), .LARGE_PAGE(LARGE_PAGE), .TOTAL_BYTES(TOTAL_BYTES),
    .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE), .STATUS_BYTE(STATUS_BYTE)
  ) u_data (
    .clk(clk), .rstN(rstN), .ceN(ceN), .dIn(dIn), .strobe(strobe), .dOut(dOut)
  );

  assign rdyBusy = 1'b1;
endmodule

// File: tb/nandfe_top_bench.sv
module nandfe_top_bench;
  localparam logic [1:0] OP_CMD = 2'd0;
  localparam logic [1:0] OP_ADR = 2'd1;
  localparam logic [1:0] OP_WR  = 2'd2;
  localparam logic [1:0] OP_RD  = 2'd3;
  localparam int NVEC = 30;

  // {requirement number, op, data or expected read value}
  localparam logic [21:0] VEC [NVEC] = '{
    // identification on a wide large-page part: R3, R4
    {4'd3, OP_CMD, 16'h0090}, {4'd3, OP_ADR, 16'h0000},
    {4'd3, OP_RD, 16'h003A},  {4'd3, OP_RD, 16'h005C},
    {4'd4, OP_RD, 16'h0051},  {4'd3, OP_RD, 16'h0055},
    {4'd9, OP_RD, 16'h0000},
    // status: R5
    {4'd5, OP_CMD, 16'h0070}, {4'd5, OP_RD, 16'h00C0}, {4'd5, OP_RD, 16'h0000},
    // program at column word 2 (byte 4): R7, R8
    {4'd8, OP_CMD, 16'h0080}, {4'd7, OP_ADR, 16'h0002}, {4'd7, OP_ADR, 16'h0000},
    {4'd6, OP_ADR, 16'h0000}, {4'd6, OP_ADR, 16'h0000}, {4'd6, OP_ADR, 16'h0000},
    {4'd8, OP_WR, 16'hA1B2},  {4'd8, OP_WR, 16'hC3D4},
    // read back, nothing before the fifth address byte: R6, R9
    {4'd6, OP_CMD, 16'h0000}, {4'd7, OP_ADR, 16'h0002}, {4'd7, OP_ADR, 16'h0000},
    {4'd6, OP_ADR, 16'h0000}, {4'd6, OP_ADR, 16'h0000}, {4'd6, OP_RD, 16'h0000},
    {4'd6, OP_ADR, 16'h0000}, {4'd9, OP_RD, 16'hA1B2},  {4'd9, OP_RD, 16'hC3D4},
    // reset command drops pending status: R11
    {4'd11, OP_CMD, 16'h0070}, {4'd11, OP_CMD, 16'h00FF}, {4'd11, OP_RD, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceN = 1'b1, cle = 1'b0, ale = 1'b0, weN = 1'b1, reN = 1'b1;
  logic [15:0] dIn = '0;
  logic [15:0] dOut;
  logic        rdyBusy;
  int          checks = 0;
  int          fails = 0;
  logic [15:0] got;

  always #2 clk = ~clk;

  nandfe_top u_nandfe_top (
    .clk(clk), .rstN(rstN), .ceN(ceN), .cle(cle), .ale(ale),
    .weN(weN), .reN(reN), .dIn(dIn), .dOut(dOut), .rdyBusy(rdyBusy)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulseWe(input logic c, input logic a, input logic ce, input logic [15:0] d);
    @(negedge clk); ceN = ce; cle = c; ale = a; dIn = d; weN = 1'b0;
    @(negedge clk); weN = 1'b1;
    @(negedge clk); cle = 1'b0; ale = 1'b0; ceN = 1'b0;
  endtask

  task automatic readWord(input logic ce, output logic [15:0] val);
    @(negedge clk); ceN = ce; reN = 1'b0;
    @(negedge clk); val = dOut; reN = 1'b1;
    @(negedge clk); ceN = 1'b0;
  endtask

  task automatic addr5(input logic [7:0] colLo, input logic [7:0] colHi);
    pulseWe(1'b0, 1'b1, 1'b0, {8'h00, colLo});
    pulseWe(1'b0, 1'b1, 1'b0, {8'h00, colHi});
    for (int i = 0; i < 3; i++) pulseWe(1'b0, 1'b1, 1'b0, 16'h0000);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    ceN  = 1'b0;
    @(negedge clk);
    // R1: nothing pending after reset, ready held
    check(dOut, 16'h0000, "R1 dOut");
    check({15'd0, rdyBusy}, 16'h0001, "R1 rdyBusy");

    for (int v = 0; v < NVEC; v++) begin
      logic [21:0] e;
      e = VEC[v];
      case (e[17:16])
        OP_CMD: pulseWe(1'b1, 1'b0, 1'b0, e[15:0]);
        OP_ADR: pulseWe(1'b0, 1'b1, 1'b0, e[15:0]);
        OP_WR:  pulseWe(1'b0, 1'b0, 1'b0, e[15:0]);
        default: begin
          readWord(1'b0, got);
          check(got, e[15:0], $sformatf("R%0d vector %0d", e[21:18], v));
        end
      endcase
    end

    // R10: chip enable high blocks the bus and consumes nothing
    pulseWe(1'b1, 1'b0, 1'b0, 16'h0070);
    readWord(1'b1, got);
    check(got, 16'h0000, "R10 ce high read");
    readWord(1'b0, got);
    check(got, 16'h00C0, "R10 status still pending");

    // R2: write strobe with ceN high is ignored during program
    pulseWe(1'b1, 1'b0, 1'b0, 16'h0080);
    addr5(8'h10, 8'h00);
    pulseWe(1'b0, 1'b0, 1'b1, 16'h9999);
    pulseWe(1'b0, 1'b0, 1'b0, 16'h4242);
    pulseWe(1'b1, 1'b0, 1'b0, 16'h0000);
    addr5(8'h10, 8'h00);
    readWord(1'b0, got);
    check(got, 16'h4242, "R2 ce-high data ignored");

    // R8: words past page plus spare are dropped
    pulseWe(1'b1, 1'b0, 1'b0, 16'h0080);
    addr5(8'h00, 8'h00);
    pulseWe(1'b0, 1'b0, 1'b0, 16'h7788);
    pulseWe(1'b1, 1'b0, 1'b0, 16'h0080);
    addr5(8'h1F, 8'h04);                      // word 0x41F = byte 2110
    pulseWe(1'b0, 1'b0, 1'b0, 16'h1111);
    pulseWe(1'b0, 1'b0, 1'b0, 16'h2222);
    pulseWe(1'b1, 1'b0, 1'b0, 16'h0000);
    addr5(8'h1F, 8'h04);
    readWord(1'b0, got);
    check(got, 16'h1111, "R8 last word kept");
    readWord(1'b0, got);
    check(got, 16'h0000, "R9 end of buffer");
    pulseWe(1'b1, 1'b0, 1'b0, 16'h0000);
    addr5(8'h00, 8'h00);
    readWord(1'b0, got);
    check(got, 16'h7788, "R8 overflow word did not wrap");

    // R1: reset pin clears a pending response
    pulseWe(1'b1, 1'b0, 1'b0, 16'h0070);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check(dOut, 16'h0000, "R1 reset drops status");

    finishRun();
  end
endmodule